// File: doc/BRIEF.md
# ASID-tagged virtual cache

A small set-associative data cache whose set index and tag both come from the virtual address. A lookup therefore decides hit or miss with no translation at all. Every line also records the address-space identifier (ASID) it was filled under. A line written by one process can never satisfy a lookup made under another, so switching the current ASID on a context switch needs no flush.

Translation is needed only when a line must be fetched after a read miss. The cache then asks an external translation unit for the physical address of the missing line, and asks memory for the line at that physical address. Writes go straight through to the next level, and a write miss does not allocate a line. Maintenance commands can flush the whole cache, flush every line of one ASID, or invalidate one virtual page, either for one ASID or for all of them. Each command walks the sets one per cycle while `busy` stalls the core.

Top module: `asid_vcache`

## Requirements
- R1: After reset every line is invalid and busy, rd_valid, rd_hit, rd_miss, wt_valid, xl_req and fill_req are low.
- R2: A read is accepted in a cycle where req_valid is high, req_we is low, and busy and cmd_valid are low. On a hit, rd_valid and rd_hit are high in the next cycle and rd_data holds the addressed 32-bit word. Address fields: bits [3:2] select the word, bits [8:4] the set, bits [31:9] the tag.
- R3: On a read miss, rd_miss is high in the next cycle and busy is high. In that same cycle xl_req asks for translation of the line address (req_va with bits [3:0] cleared) under the request ASID. After xl_ack, fill_req asks for the line at the returned physical address with bits [3:0] cleared.
- R4: In the cycle after fill_valid is sampled, rd_valid is high, rd_hit is low, busy is low, and rd_data holds the requested word. Word k of fill_line is bits [32k+31:32k]. The line is installed, so a repeat read hits.
- R5: A hit needs the valid bit, the virtual tag and the stored ASID to all match. The same virtual address under another ASID misses, and both copies then stay resident.
- R6: An accepted write drives wt_valid, wt_va, wt_asid and wt_data in the same cycle. A write hit updates the cached word. A write miss allocates nothing. A write produces no read response.
- R7: Command code 0 (flush all) is accepted when cmd_valid is high and busy is low. It holds busy high for exactly SETS cycles, after which every line misses.
- R8: Command code 1 invalidates only the lines whose stored ASID equals cmd_asid.
- R9: Command code 2 invalidates the lines whose virtual page (bits [31:12]) equals that of cmd_va and whose ASID equals cmd_asid. Command code 3 does the same for every ASID. Lines of other pages are kept.
- R10: While busy or cmd_valid is high, a request is not accepted: no write-through, no read response.
- R11: A refill goes into the lowest-numbered invalid way of the set. If the set is full, it goes into the way picked by a tree pseudo-LRU that every hit and fill updates. Example: fill ways 0..3, then hit way 0; the next refill replaces way 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_va | input | VAW | Virtual byte address |
| req_asid | input | ASIDW | Current address-space identifier |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Refill or command walk in progress; requests stall |
| rd_valid | output | 1 | Read data valid |
| rd_hit | output | 1 | Read response came from a hit |
| rd_miss | output | 1 | Read missed; refill started |
| rd_data | output | DW | Read data |
| wt_valid | output | 1 | Write-through to next level |
| wt_va | output | VAW | Write-through virtual address |
| wt_asid | output | ASIDW | Write-through ASID |
| wt_data | output | DW | Write-through data |
| cmd_valid | input | 1 | Maintenance command request |
| cmd_op | input | 2 | 0 flush all, 1 flush ASID, 2 invalidate page for ASID, 3 invalidate page for all ASIDs |
| cmd_asid | input | ASIDW | ASID operand |
| cmd_va | input | VAW | Address inside the page to invalidate |
| xl_req | output | 1 | Translation request |
| xl_va | output | VAW | Line address to translate |
| xl_asid | output | ASIDW | ASID of the translation |
| xl_ack | input | 1 | Translation done |
| xl_pa | input | PAW | Translated physical address |
| fill_req | output | 1 | Line fetch request |
| fill_pa | output | PAW | Physical line address |
| fill_valid | input | 1 | Line data returned |
| fill_line | input | LINE_WORDS*DW | Refill line |

## Verification
A hit or miss flag is due one cycle after the accepting edge, and the translation request comes up in that same cycle. The fetch request follows one cycle after translation is acknowledged. Refill data is due one cycle after the line is returned. A command keeps busy high for exactly SETS cycles. The bench drives and samples on the falling edge and steps exactly that many edges before each comparison. It answers translation and fetch requests at the falling edge after they appear, so every miss has a fixed, known timeline.

// File: rtl/asid_vcache.sv
module asid_vcache #(
  parameter int VAW        = 32,
  parameter int PAW        = 32,
  parameter int DW         = 32,
  parameter int ASIDW      = 8,
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 4,
  parameter int SETS       = 32,
  parameter int PAGE_BITS  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [VAW-1:0]           req_va,
  input  logic [ASIDW-1:0]         req_asid,
  input  logic [DW-1:0]            req_wdata,
  output logic                     busy,
  output logic                     rd_valid,
  output logic                     rd_hit,
  output logic                     rd_miss,
  output logic [DW-1:0]            rd_data,
  output logic                     wt_valid,
  output logic [VAW-1:0]           wt_va,
  output logic [ASIDW-1:0]         wt_asid,
  output logic [DW-1:0]            wt_data,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [ASIDW-1:0]         cmd_asid,
  input  logic [VAW-1:0]           cmd_va,
  output logic                     xl_req,
  output logic [VAW-1:0]           xl_va,
  output logic [ASIDW-1:0]         xl_asid,
  input  logic                     xl_ack,
  input  logic [PAW-1:0]           xl_pa,
  output logic                     fill_req,
  output logic [PAW-1:0]           fill_pa,
  input  logic                     fill_valid,
  input  logic [LINE_WORDS*DW-1:0] fill_line
);

  localparam int BYTE_BITS = $clog2(DW / 8);
  localparam int WORD_BITS = $clog2(LINE_WORDS);
  localparam int OFF_BITS  = BYTE_BITS + WORD_BITS;
  localparam int IDX_BITS  = $clog2(SETS);
  localparam int TAG_LO    = OFF_BITS + IDX_BITS;
  localparam int TAGW      = VAW - TAG_LO;
  localparam int VPN_OFF   = PAGE_BITS - TAG_LO;
  localparam int VPNW      = VAW - PAGE_BITS;
  localparam int WAY_BITS  = $clog2(WAYS);
  localparam int LRU_BITS  = WAYS - 1;

  localparam logic [1:0] OP_ALL  = 2'd0;
  localparam logic [1:0] OP_ASID = 2'd1;
  localparam logic [1:0] OP_PAGE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_XLATE, S_FETCH, S_WALK} st_e;

  function automatic logic [WAY_BITS-1:0] pick_lru(input logic [LRU_BITS-1:0] t);
    int n;
    logic [LRU_BITS-1:0] s;
    n = 1;
    for (int l = 0; l < WAY_BITS; l++) begin
      s = t >> (n - 1);
      n = 2 * n + (s[0] ? 1 : 0);
    end
    return WAY_BITS'(n - WAYS);
  endfunction

  function automatic logic [LRU_BITS-1:0] touch_lru(input logic [LRU_BITS-1:0] t,
                                                    input logic [WAY_BITS-1:0] w);
    int n;
    logic [LRU_BITS-1:0] r;
    logic [WAY_BITS-1:0] ws;
    r = t;
    n = 1;
    for (int l = 0; l < WAY_BITS; l++) begin
      ws = w >> (WAY_BITS - 1 - l);
      r  = ws[0] ? (r & ~(LRU_BITS'(1) << (n - 1))) : (r | (LRU_BITS'(1) << (n - 1)));
      n  = 2 * n + (ws[0] ? 1 : 0);
    end
    return r;
  endfunction

  logic [WAYS-1:0]     vld_q [SETS];
  logic [LRU_BITS-1:0] lru_q [SETS];
  logic [TAGW-1:0]     tag_q [SETS][WAYS];
  logic [ASIDW-1:0]    asid_q[SETS][WAYS];
  logic [DW-1:0]       dat_q [SETS][WAYS][LINE_WORDS];

  st_e                   st_q;
  logic [IDX_BITS-1:0]   m_idx_q, wk_idx_q;
  logic [TAGW-1:0]       m_tag_q;
  logic [ASIDW-1:0]      m_asid_q, wk_asid_q;
  logic [WORD_BITS-1:0]  m_wrd_q;
  logic [PAW-OFF_BITS-1:0] m_pa_q;
  logic [1:0]            wk_op_q;
  logic [VPNW-1:0]       wk_vpn_q;

  logic [IDX_BITS-1:0]  r_idx;
  logic [TAGW-1:0]      r_tag;
  logic [WORD_BITS-1:0] r_wrd;
  logic [WAYS-1:0]      hit_vec, kill_vec;
  logic [WAY_BITS-1:0]  hit_way, vic;
  logic                 hit_any, accept, cmd_acc, fill_go;
  logic [DW-1:0]        hit_word, fill_word;
  logic                 unused_bits;

  assign r_idx = req_va[TAG_LO-1:OFF_BITS];
  assign r_tag = req_va[VAW-1:TAG_LO];
  assign r_wrd = req_va[OFF_BITS-1:BYTE_BITS];
  assign unused_bits = ^{req_va[BYTE_BITS-1:0], cmd_va[PAGE_BITS-1:0], xl_pa[OFF_BITS-1:0]};

  assign busy    = (st_q != S_IDLE);
  assign accept  = req_valid && !busy && !cmd_valid;
  assign cmd_acc = cmd_valid && !busy;
  assign fill_go = (st_q == S_FETCH) && fill_valid;

  assign wt_valid = accept && req_we;
  assign wt_va    = req_va;
  assign wt_asid  = req_asid;
  assign wt_data  = req_wdata;

  assign xl_req   = (st_q == S_XLATE);
  assign xl_va    = {m_tag_q, m_idx_q, {OFF_BITS{1'b0}}};
  assign xl_asid  = m_asid_q;
  assign fill_req = (st_q == S_FETCH);
  assign fill_pa  = {m_pa_q, {OFF_BITS{1'b0}}};

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[r_idx][w] && (tag_q[r_idx][w] == r_tag) && (asid_q[r_idx][w] == req_asid);
      if (hit_vec[w]) hit_way = WAY_BITS'(w);
    end
  end
  assign hit_any  = |hit_vec;
  assign hit_word = dat_q[r_idx][hit_way][r_wrd];

  always_comb begin
    vic = pick_lru(lru_q[m_idx_q]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[m_idx_q][w]) vic = WAY_BITS'(w);
  end

  always_comb begin
    fill_word = '0;
    for (int k = 0; k < LINE_WORDS; k++)
      if (m_wrd_q == WORD_BITS'(k)) fill_word = fill_line[k*DW +: DW];
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      logic am, pm;
      am = (asid_q[wk_idx_q][w] == wk_asid_q);
      pm = (tag_q[wk_idx_q][w][TAGW-1:VPN_OFF] == wk_vpn_q);
      case (wk_op_q)
        OP_ALL:  kill_vec[w] = 1'b1;
        OP_ASID: kill_vec[w] = am;
        OP_PAGE: kill_vec[w] = pm && am;
        default: kill_vec[w] = pm;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      rd_valid  <= 1'b0;
      rd_hit    <= 1'b0;
      rd_miss   <= 1'b0;
      rd_data   <= '0;
      m_idx_q   <= '0;
      m_tag_q   <= '0;
      m_asid_q  <= '0;
      m_wrd_q   <= '0;
      m_pa_q    <= '0;
      wk_idx_q  <= '0;
      wk_op_q   <= '0;
      wk_asid_q <= '0;
      wk_vpn_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
      rd_miss  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (cmd_acc) begin
            st_q      <= S_WALK;
            wk_idx_q  <= '0;
            wk_op_q   <= cmd_op;
            wk_asid_q <= cmd_asid;
            wk_vpn_q  <= cmd_va[VAW-1:PAGE_BITS];
          end else if (accept) begin
            if (hit_any) begin
              lru_q[r_idx] <= touch_lru(lru_q[r_idx], hit_way);
              if (!req_we) begin
                rd_valid <= 1'b1;
                rd_hit   <= 1'b1;
                rd_data  <= hit_word;
              end
            end else if (!req_we) begin
              rd_miss  <= 1'b1;
              st_q     <= S_XLATE;
              m_idx_q  <= r_idx;
              m_tag_q  <= r_tag;
              m_asid_q <= req_asid;
              m_wrd_q  <= r_wrd;
            end
          end
        end
        S_XLATE: begin
          if (xl_ack) begin
            m_pa_q <= xl_pa[PAW-1:OFF_BITS];
            st_q   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (fill_valid) begin
            vld_q[m_idx_q][vic] <= 1'b1;
            lru_q[m_idx_q]      <= touch_lru(lru_q[m_idx_q], vic);
            rd_valid            <= 1'b1;
            rd_data             <= fill_word;
            st_q                <= S_IDLE;
          end
        end
        default: begin
          vld_q[wk_idx_q] <= vld_q[wk_idx_q] & ~kill_vec;
          wk_idx_q        <= wk_idx_q + 1'b1;
          if (wk_idx_q == IDX_BITS'(SETS - 1)) st_q <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept && req_we && hit_any) begin
      dat_q[r_idx][hit_way][r_wrd] <= req_wdata;
    end else if (fill_go) begin
      tag_q[m_idx_q][vic]  <= m_tag_q;
      asid_q[m_idx_q][vic] <= m_asid_q;
      for (int k = 0; k < LINE_WORDS; k++)
        dat_q[m_idx_q][vic][k] <= fill_line[k*DW +: DW];
    end
  end

endmodule

// File: rtl/asid_vcache_chk.sv
module asid_vcache_chk #(
  parameter int SETS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_we,
  input logic cmd_valid,
  input logic busy,
  input logic rd_valid,
  input logic rd_hit,
  input logic rd_miss,
  input logic wt_valid,
  input logic xl_req,
  input logic fill_req,
  input logic fill_valid
);

  localparam int CW = $clog2(SETS + 1);
  logic [CW-1:0] walk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 walk_cnt <= '0;
    else if (cmd_valid && !busy) walk_cnt <= CW'(SETS);
    else if (walk_cnt != '0)     walk_cnt <= walk_cnt - 1'b1;
  end

  p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit && rd_miss));

  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !busy && !cmd_valid) |=> (rd_hit || rd_miss));

  p_miss_xlate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |-> (busy && xl_req && !fill_req));

  p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (rd_valid && !rd_hit && !busy));

  p_walk_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_cnt != '0) |-> busy);

  p_walk_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_cnt == CW'(1)) |=> !busy);

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || cmd_valid) |-> !wt_valid);

endmodule

bind asid_vcache asid_vcache_chk #(.SETS(SETS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .cmd_valid(cmd_valid), .busy(busy), .rd_valid(rd_valid), .rd_hit(rd_hit),
  .rd_miss(rd_miss), .wt_valid(wt_valid), .xl_req(xl_req), .fill_req(fill_req),
  .fill_valid(fill_valid)
);

// File: tb/asid_vcache_tb_top.sv
module asid_vcache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_va = '0, req_wdata = '0;
  logic [7:0] req_asid = '0;
  logic busy, rd_valid, rd_hit, rd_miss, wt_valid;
  logic [31:0] rd_data, wt_va, wt_data;
  logic [7:0] wt_asid;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_asid = '0;
  logic [31:0] cmd_va = '0;
  logic xl_req, fill_req;
  logic [31:0] xl_va, fill_pa;
  logic [7:0] xl_asid;
  logic xl_ack = 1'b0, fill_valid = 1'b0;
  logic [31:0] xl_pa = '0;
  logic [127:0] fill_line = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_vcache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_va(req_va),
    .req_asid(req_asid), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_data(rd_data), .wt_valid(wt_valid),
    .wt_va(wt_va), .wt_asid(wt_asid), .wt_data(wt_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_asid(cmd_asid), .cmd_va(cmd_va), .xl_req(xl_req),
    .xl_va(xl_va), .xl_asid(xl_asid), .xl_ack(xl_ack), .xl_pa(xl_pa),
    .fill_req(fill_req), .fill_pa(fill_pa), .fill_valid(fill_valid), .fill_line(fill_line)
  );

  function automatic logic [31:0] xlate(input logic [31:0] va, input logic [7:0] asid);
    return va ^ {asid, 24'h0};
  endfunction

  function automatic logic [127:0] mkline(input logic [31:0] pa);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = {pa[31:4], 2'(k), 2'b00} ^ 32'h5A00_00C3;
    return l;
  endfunction

  function automatic logic [31:0] expw(input logic [31:0] va, input logic [7:0] asid);
    logic [31:0] pa;
    pa = xlate(va, asid);
    return {pa[31:4], va[3:2], 2'b00} ^ 32'h5A00_00C3;
  endfunction

  always @(negedge clk) begin
    xl_ack     <= xl_req;
    xl_pa      <= xlate(xl_va, xl_asid);
    fill_valid <= fill_req;
    fill_line  <= mkline(fill_pa);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] asid, input logic [31:0] va, input bit exp_hit,
                    input logic [31:0] exp_d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_asid = asid; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(rd_valid && rd_hit && !rd_miss, {tag, " hit flags"}, {29'b0, rd_valid, rd_hit, rd_miss}, 32'h6);
      chk(rd_data == exp_d, {tag, " hit data"}, rd_data, exp_d);
    end else begin
      chk(rd_miss && !rd_valid && busy, {tag, " miss flags"}, {29'b0, rd_miss, rd_valid, busy}, 32'h5);
      chk(xl_req && xl_va == {va[31:4], 4'h0} && xl_asid == asid, "R3 translation request",
          xl_va, {va[31:4], 4'h0});
      @(negedge clk);
      chk(fill_req && fill_pa == {xlate(va, asid)[31:4], 4'h0}, "R3 fetch request",
          fill_pa, {xlate(va, asid)[31:4], 4'h0});
      @(negedge clk);
      chk(rd_valid && !rd_hit && !busy, "R4 refill flags", {29'b0, rd_valid, rd_hit, busy}, 32'h4);
      chk(rd_data == exp_d, {tag, " R4 refill data"}, rd_data, exp_d);
    end
  endtask

  task automatic wr(input logic [7:0] asid, input logic [31:0] va, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_asid = asid; req_va = va; req_wdata = d;
    #1;
    chk(wt_valid && wt_va == va && wt_asid == asid && wt_data == d, "R6 write-through", wt_data, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rd_valid && !rd_miss && !busy, "R6 no read response", {30'b0, rd_valid, rd_miss}, 32'h0);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] asid, input logic [31:0] va,
                     input bit hold_req, output int cycles);
    bit stall_ok;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_asid = asid; cmd_va = va;
    if (hold_req) begin
      req_valid = 1'b1; req_we = 1'b1; req_va = 32'h0000_5000; req_asid = 8'd9; req_wdata = 32'h1;
      #1;
      chk(!wt_valid, "R10 command wins over request", {31'b0, wt_valid}, 32'h0);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cycles = 0;
    stall_ok = 1'b1;
    while (busy && cycles < 1000) begin
      cycles++;
      if (wt_valid || rd_valid || rd_miss) stall_ok = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (hold_req) chk(stall_ok, "R10 stalled while busy", {31'b0, stall_ok}, 32'h1);
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  asid;
    logic [31:0] va;
    logic [31:0] wd;
    logic        hit;
    logic        fill;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd1, 32'h0000_1004, 32'h0,         1'b0, 1'b1},  // R3 R4 first miss
    '{1'b0, 8'd1, 32'h0000_1008, 32'h0,         1'b1, 1'b1},  // R2 hit same line
    '{1'b0, 8'd2, 32'h0000_1004, 32'h0,         1'b0, 1'b1},  // R5 other ASID misses
    '{1'b0, 8'd1, 32'h0000_1004, 32'h0,         1'b1, 1'b1},  // R5 both resident
    '{1'b1, 8'd1, 32'h0000_1008, 32'hDEAD_BEEF, 1'b0, 1'b0},  // R6 write hit
    '{1'b0, 8'd1, 32'h0000_1008, 32'hDEAD_BEEF, 1'b1, 1'b0},  // R6 updated word
    '{1'b0, 8'd2, 32'h0000_1008, 32'h0,         1'b1, 1'b1},  // R5 other copy untouched
    '{1'b1, 8'd3, 32'h0000_2000, 32'h1234_5678, 1'b0, 1'b0},  // R6 write miss
    '{1'b0, 8'd3, 32'h0000_2000, 32'h0,         1'b0, 1'b1}   // R6 no allocate
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_valid && !rd_hit && !rd_miss && !wt_valid && !xl_req && !fill_req,
        "R1 reset outputs", {25'b0, busy, rd_valid, rd_hit, rd_miss, wt_valid, xl_req, fill_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].asid, VEC[i].va, VEC[i].wd);
      else rd(VEC[i].asid, VEC[i].va, VEC[i].hit,
              VEC[i].fill ? expw(VEC[i].va, VEC[i].asid) : VEC[i].wd, "R2/R5/R6 table");
    end

    // R11 replacement in set 3
    rd(8'd5, 32'h0000_0030, 1'b0, expw(32'h0000_0030, 8'd5), "R11 fill A");
    rd(8'd5, 32'h0000_0230, 1'b0, expw(32'h0000_0230, 8'd5), "R11 fill B");
    rd(8'd5, 32'h0000_0430, 1'b0, expw(32'h0000_0430, 8'd5), "R11 fill C");
    rd(8'd5, 32'h0000_0630, 1'b0, expw(32'h0000_0630, 8'd5), "R11 fill D");
    rd(8'd5, 32'h0000_0030, 1'b1, expw(32'h0000_0030, 8'd5), "R11 touch A");
    rd(8'd5, 32'h0000_0830, 1'b0, expw(32'h0000_0830, 8'd5), "R11 fill E");
    rd(8'd5, 32'h0000_0030, 1'b1, expw(32'h0000_0030, 8'd5), "R11 A kept");
    rd(8'd5, 32'h0000_0230, 1'b1, expw(32'h0000_0230, 8'd5), "R11 B kept");
    rd(8'd5, 32'h0000_0630, 1'b1, expw(32'h0000_0630, 8'd5), "R11 D kept");
    rd(8'd5, 32'h0000_0430, 1'b0, expw(32'h0000_0430, 8'd5), "R11 C evicted");

    // R7 flush all, with R10 stall
    cmd(2'd0, 8'd0, 32'h0, 1'b1, nb);
    chk(nb == SETS, "R7 busy length", nb, SETS);
    rd(8'd5, 32'h0000_0030, 1'b0, expw(32'h0000_0030, 8'd5), "R7 flushed");
    rd(8'd1, 32'h0000_1004, 1'b0, expw(32'h0000_1004, 8'd1), "R7 flushed");

    // R8 flush by ASID
    rd(8'd6, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd6), "R8 setup");
    rd(8'd7, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd7), "R8 setup");
    rd(8'd7, 32'h0000_4010, 1'b0, expw(32'h0000_4010, 8'd7), "R8 setup");
    cmd(2'd1, 8'd6, 32'h0, 1'b0, nb);
    chk(nb == SETS, "R8 busy length", nb, SETS);
    rd(8'd7, 32'h0000_3000, 1'b1, expw(32'h0000_3000, 8'd7), "R8 other ASID kept");
    rd(8'd6, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd6), "R8 ASID flushed");

    // R9 page invalidate
    cmd(2'd2, 8'd7, 32'h0000_3ABC, 1'b0, nb);
    rd(8'd6, 32'h0000_3000, 1'b1, expw(32'h0000_3000, 8'd6), "R9 other ASID same page kept");
    rd(8'd7, 32'h0000_4010, 1'b1, expw(32'h0000_4010, 8'd7), "R9 other page kept");
    rd(8'd7, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd7), "R9 page line removed");
    cmd(2'd3, 8'd0, 32'h0000_3ABC, 1'b0, nb);
    rd(8'd6, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd6), "R9 all-ASID removal");
    rd(8'd7, 32'h0000_3000, 1'b0, expw(32'h0000_3000, 8'd7), "R9 all-ASID removal");
    rd(8'd7, 32'h0000_4010, 1'b1, expw(32'h0000_4010, 8'd7), "R9 other page kept");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule